// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a system-on-chip. It holds a 16-bit control word and accepts writes to a separate service address. Software turns the watchdog on and sets a timeout in half-second steps. A prescaler derives a 2 Hz tick from the input clock, and a down-counter counts those ticks. To keep the system alive, software must write two fixed key words to the service address, in the right order. Only that completed pair reloads the counter.

If software stops servicing the watchdog, the counter runs out. The block then raises a fixed-length internal reset pulse. It can also raise an external reset pulse if software has asked for that. Two active-low control bits let software force either reset at once, without waiting for the counter. Two freeze bits hold the count still while the chip reports debug or low-power mode. Once the enable bit is set, only a system reset clears it.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the control word reads 0x0030, the count reads 0, and both reset outputs are low.
- R2: Control bit 0 is the enable bit. Once it has been written as 1, later control writes cannot clear it.
- R3: Writing enable=1 while the watchdog is disabled loads the count from control bits [15:8]. While the watchdog runs, the count drops by one every CLK_HZ/2 clock cycles.
- R4: The counter expires on the tick that follows a count of zero, which is (T+1)*CLK_HZ/2 running cycles after the load. Expiry pulses the internal reset and reloads the count from bits [15:8].
- R5: A service write of 0x5555 followed directly by a service write of 0xAAAA reloads the count and restarts the prescaler. A service write of any other value in between discards the pair. A lone 0xAAAA does nothing.
- R6: A control write with bit 4 at 0, where the enable bit is 1 after the write, starts an internal reset pulse on the next cycle. The same write while the watchdog stays disabled starts no pulse.
- R7: A control write with bit 5 at 0 starts an external reset pulse on the next cycle, whether or not the watchdog is enabled.
- R8: When control bit 3 is 1, expiry also pulses the external reset.
- R9: When control bit 1 is 1, counting is frozen while debug_i is high. When control bit 2 is 1, counting is frozen while lowpwr_i is high.
- R10: Each reset pulse lasts exactly PULSE_LEN cycles (default 4). A trigger that arrives while that output's pulse is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the control word, 1 selects the service address |
| wr_data | input | 16 | Write data |
| debug_i | input | 1 | Chip is in debug mode |
| lowpwr_i | input | 1 | Chip is in low-power mode |
| ctrl_rdata | output | 16 | Current control word |
| count_rdata | output | 8 | Current count value |
| int_rst_o | output | 1 | Internal reset pulse |
| ext_rst_o | output | 1 | External reset pulse |

## Verification
A wrong prescaler or counter state shows up as a count_rdata value that is off within one tick period. It also moves the expiry pulse by whole tick periods. A stuck key-sequence flag shows up in the first service pair, because the count does not return to the timeout on the cycle after the 0xAAAA write. A wrong pulse counter shows up within PULSE_LEN+1 cycles of any trigger: the pulse has the wrong length or restarts when it should not. The bench compares all four outputs against a behavioural model on every clock.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int CLK_HZ    = 24_000_000,
  parameter int PULSE_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        debug_i,
  input  logic        lowpwr_i,
  output logic [15:0] ctrl_rdata,
  output logic [7:0]  count_rdata,
  output logic        int_rst_o,
  output logic        ext_rst_o
);
  localparam int DIV = (CLK_HZ / 2 < 1) ? 1 : CLK_HZ / 2;
  localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int LW  = $clog2(PULSE_LEN + 1);
  localparam logic [15:0] CTRL_RST  = 16'h0030;
  localparam logic [15:0] CTRL_MASK = 16'hFF3E;
  localparam logic [15:0] KEY_A = 16'h5555;
  localparam logic [15:0] KEY_B = 16'hAAAA;

  logic [15:0]   ctrl_q;
  logic [7:0]    cnt_q;
  logic [PW-1:0] pre_q;
  logic          armed_q;
  logic [LW-1:0] ip_q, ep_q;

  wire ctrl_wr  = wr_en & ~wr_sel;
  wire svc_wr   = wr_en & wr_sel;
  wire en_d     = ctrl_q[0] | (ctrl_wr & wr_data[0]);
  wire en_rise  = ctrl_wr & wr_data[0] & ~ctrl_q[0];
  wire key_done = svc_wr & armed_q & (wr_data == KEY_B);
  wire frozen   = (ctrl_q[1] & debug_i) | (ctrl_q[2] & lowpwr_i);
  wire running  = ctrl_q[0] & ~frozen;
  wire tick     = running && (pre_q == PW'(DIV - 1));
  wire expire   = tick && (cnt_q == 8'd0);
  wire int_trig = expire | (ctrl_wr & ~wr_data[4] & en_d);
  wire ext_trig = (expire & ctrl_q[3]) | (ctrl_wr & ~wr_data[5]);
  wire [7:0] load_val = en_rise ? wr_data[15:8] : ctrl_q[15:8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= CTRL_RST;
    else if (ctrl_wr) ctrl_q <= (wr_data & CTRL_MASK) | {15'd0, en_d};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed_q <= 1'b0;
    else if (svc_wr) armed_q <= (wr_data == KEY_A);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= 8'd0;
      pre_q <= '0;
    end else if (en_rise | key_done) begin
      cnt_q <= load_val;
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= expire ? ctrl_q[15:8] : cnt_q - 8'd1;
    end else if (running) begin
      pre_q <= pre_q + PW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ip_q <= '0;
      ep_q <= '0;
    end else begin
      if (ip_q != '0) ip_q <= ip_q - LW'(1);
      else if (int_trig) ip_q <= LW'(PULSE_LEN);
      if (ep_q != '0) ep_q <= ep_q - LW'(1);
      else if (ext_trig) ep_q <= LW'(PULSE_LEN);
    end

  assign ctrl_rdata  = ctrl_q;
  assign count_rdata = cnt_q;
  assign int_rst_o   = (ip_q != '0);
  assign ext_rst_o   = (ep_q != '0);

  a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[0] |=> ctrl_rdata[0]);

  a_r5_key_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && armed_q && wr_data == KEY_B) |=> (count_rdata == $past(ctrl_rdata[15:8])));

  a_r6_force_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[4] && (ctrl_rdata[0] || wr_data[0]) && !int_rst_o) |=> int_rst_o);

  a_r7_force_external: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[5] && !ext_rst_o) |=> ext_rst_o);

  a_r9_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ((ctrl_rdata[1] && debug_i) || (ctrl_rdata[2] && lowpwr_i))) |=> $stable(count_rdata));

  a_r10_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_q <= LW'(PULSE_LEN)) && (ep_q <= LW'(PULSE_LEN)));
endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
  localparam int CLK_HZ = 16;
  localparam int DIV    = CLK_HZ / 2;
  localparam int PLEN   = 4;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel = 0, debug_i = 0, lowpwr_i = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] ctrl_rdata;
  logic [7:0]  count_rdata;
  logic        int_rst_o, ext_rst_o;

  keyed_watchdog #(.CLK_HZ(CLK_HZ), .PULSE_LEN(PLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .debug_i(debug_i), .lowpwr_i(lowpwr_i), .ctrl_rdata(ctrl_rdata),
    .count_rdata(count_rdata), .int_rst_o(int_rst_o), .ext_rst_o(ext_rst_o));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  logic [15:0] m_ctrl;
  int m_load, m_run, m_ileft, m_eleft;
  bit m_armed;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit run, cw, sw, nen, mexp, it, et;
    cycles++;
    if (!rst_n) begin
      m_ctrl = 16'h0030; m_load = 0; m_run = 0; m_ileft = 0; m_eleft = 0; m_armed = 0;
    end else begin
      run  = m_ctrl[0] && !((m_ctrl[1] && debug_i) || (m_ctrl[2] && lowpwr_i));
      cw   = wr_en && !wr_sel;
      sw   = wr_en && wr_sel;
      nen  = m_ctrl[0] || (cw && wr_data[0]);
      mexp = 0;
      if (cw && wr_data[0] && !m_ctrl[0]) begin
        m_load = wr_data[15:8]; m_run = 0;
      end else if (sw && m_armed && wr_data == 16'hAAAA) begin
        m_load = m_ctrl[15:8]; m_run = 0;
      end else if (run) begin
        m_run++;
        if (m_run == (m_load + 1) * DIV) begin
          mexp = 1; m_load = m_ctrl[15:8]; m_run = 0;
        end
      end
      if (sw) m_armed = (wr_data == 16'h5555);
      it = mexp || (cw && !wr_data[4] && nen);
      et = (mexp && m_ctrl[3]) || (cw && !wr_data[5]);
      if (m_ileft > 0) m_ileft--; else if (it) m_ileft = PLEN;
      if (m_eleft > 0) m_eleft--; else if (et) m_eleft = PLEN;
      if (cw) m_ctrl = (wr_data & 16'hFF3E) | {15'd0, nen};
    end
    #1;
    check(cur_req, "ctrl_rdata", ctrl_rdata, m_ctrl);
    check(cur_req, "count_rdata", count_rdata, m_load - m_run / DIV);
    check(cur_req, "int_rst_o", int_rst_o, m_ileft != 0);
    check(cur_req, "ext_rst_o", ext_rst_o, m_eleft != 0);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog timeout actual=%0d expected=<20000", cycles);
    finish_up();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    check("R1", "reset ctrl", ctrl_rdata, 16'h0030);
    check("R1", "reset count", count_rdata, 0);
    check("R1", "reset outs", {int_rst_o, ext_rst_o}, 0);
    cur_req = "R3"; wr(0, 16'h0331); idle(20);
    cur_req = "R4"; idle(20);
    cur_req = "R2"; wr(0, 16'h0330); idle(1);
    check("R2", "enable kept", ctrl_rdata, 16'h0331);
    cur_req = "R5"; idle(10); wr(1, 16'h5555); wr(1, 16'hAAAA); idle(12);
    wr(1, 16'h5555); wr(1, 16'h1234); wr(1, 16'hAAAA); idle(5);
    wr(1, 16'hAAAA); idle(40);
    cur_req = "R9"; wr(0, 16'h0333); debug_i = 1; idle(30);
    debug_i = 0; idle(10); wr(0, 16'h0335); lowpwr_i = 1; idle(10);
    debug_i = 1; idle(10); lowpwr_i = 0; debug_i = 0; idle(40);
    cur_req = "R8"; wr(0, 16'h0339); idle(40);
    cur_req = "R10"; wr(0, 16'h0329); idle(1); wr(0, 16'h0329); idle(8);
    cur_req = "R7"; wr(0, 16'h0319); idle(8);
    cur_req = "R6"; rst_n = 0; idle(2); rst_n = 1;
    wr(0, 16'h0020); idle(6);
    check("R6", "no pulse when disabled", int_rst_o, 0);
    cur_req = "R7"; wr(0, 16'h0010); idle(6);
    finish_up();
  end
endmodule